// File: doc/BRIEF.md
# Serial Two-Stage Attenuation Control Register

This block is the digital front end that sets a pair of cascaded step attenuators from a three-wire serial link. The link carries a data line, a serial clock and an active-high latch enable. The block samples all three lines with a faster system clock. Each serial clock rise moves one data bit into a ten-bit shift register. When latch enable falls, the shift register is copied into a ten-bit holding latch, and only then do the outputs change.

The holding latch drives two five-bit attenuation codes, one for each stage. Each code is expanded into five section enables with binary weights of 1, 2, 4, 8 and 16 dB. This gives 0 to 31 dB per stage and up to 62 dB for the chain. A separate loop-enable input chooses the input path: high selects normal transmit through the attenuators, and low selects loopback through the mixer.

Top module: `attn_serial_ctrl`

## Requirements
- R1: A ten-bit word is sent most significant bit first. After ten serial clock rises, the first bit sent sits in bit 9 and the last bit sent sits in bit 0.
- R2: One data bit is captured on each rising edge of the serial clock, as seen through the synchronizers. A falling edge captures nothing.
- R3: The codes and section enables change only when latch enable falls. Shifting bits while latch enable stays high leaves the outputs unchanged.
- R4: Word bits 4..0 give the first-stage code `stage1Code`. Word bits 9..5 give the second-stage code `stage2Code`.
- R5: `sectionEn[k]` for k = 0..4 enables the 2^k dB section of the first stage. `sectionEn[5+k]` enables the 2^k dB section of the second stage. A value of 1 means attenuate and 0 means pass.
- R6: An all-zero word gives 0 dB on both stages. An all-ones word gives 31 on both codes, with all ten section enables set.
- R7: One system clock after `loopEnIn` is sampled, `attnPathSel` equals it and `mixerPathSel` equals its inverse. Exactly one of the two is high.
- R8: Reset clears the shift register, the holding latch and `updateStrobe` to zero, so both stages start at minimum attenuation.
- R9: `updateStrobe` goes high for exactly one system clock each time the latch loads, in the same cycle as the new codes appear.
- R10: If latch enable falls after fewer or more than ten serial clocks, the latch takes whatever the register holds. That is the last ten bits shifted in, including bits left over from earlier words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial clock; data is taken on its rising edge |
| serData | input | 1 | Serial data, most significant bit first |
| serLe | input | 1 | Latch enable, active high; a falling edge loads the latch |
| loopEnIn | input | 1 | High for transmit path, low for loopback path |
| stage1Code | output | 5 | First-stage attenuation code in dB |
| stage2Code | output | 5 | Second-stage attenuation code in dB |
| sectionEn | output | 10 | Per-section attenuate enables, stage 1 in the low half |
| updateStrobe | output | 1 | One-cycle pulse when the latch loads |
| attnPathSel | output | 1 | Input routed to the attenuator chain |
| mixerPathSel | output | 1 | Input routed to the loopback mixer |

## Verification
The shift register cannot be seen at the ports, so it shows up only at the next latch event. A wrong bit order, a dropped edge or a doubled edge appears as a wrong code in the cycle where `updateStrobe` pulses, about three system clocks after latch enable falls. A holding latch that follows the shift register too early shows up as a code change while latch enable is still high. The bench checks for this directly. Short and long words are sent on purpose, so that leftover bits from an earlier word reach the outputs and expose any register that clears itself between words.

// File: rtl/attn_ctrl_pkg.sv
package attn_ctrl_pkg;
  // Strobes passed from the control side to the datapath.
  typedef struct packed {
    logic shiftBit;   // synchronized serial clock rose
    logic loadLatch;  // synchronized latch enable fell
  } ctrlStrobe_t;
endpackage

// File: rtl/attn_ctrl_sync.sv
module attn_ctrl_sync
  import attn_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serLe,
  output ctrlStrobe_t strobes,
  output logic        dataBit
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] clkSync;
  logic [LAST:0] dataSync;
  logic [LAST:0] leSync;
  logic          clkPrev;
  logic          lePrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync  <= '0;
      dataSync <= '0;
      leSync   <= '0;
      clkPrev  <= 1'b0;
      lePrev   <= 1'b0;
    end else begin
      clkSync  <= {clkSync[LAST-1:0], serClk};
      dataSync <= {dataSync[LAST-1:0], serData};
      leSync   <= {leSync[LAST-1:0], serLe};
      clkPrev  <= clkSync[LAST];
      lePrev   <= leSync[LAST];
    end
  end

  // Data runs through the same depth as the clock, so the two stay aligned.
  assign strobes.shiftBit  = clkSync[LAST] & ~clkPrev;
  assign strobes.loadLatch = ~leSync[LAST] & lePrev;
  assign dataBit           = dataSync[LAST];
endmodule

// File: rtl/attn_ctrl_datapath.sv
module attn_ctrl_datapath
  import attn_ctrl_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int STAGES = 2,
  localparam int WORD_W = CODE_W * STAGES
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobes,
  input  logic              dataBit,
  input  logic              loopEnIn,
  output logic [WORD_W-1:0] latchWord,
  output logic [WORD_W-1:0] sectionEn,
  output logic              updateStrobe,
  output logic              attnPathSel,
  output logic              mixerPathSel
);
  logic [WORD_W-1:0] shiftReg;
  logic              pathReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg     <= '0;
      latchWord    <= '0;
      updateStrobe <= 1'b0;
      pathReg      <= 1'b1;
    end else begin
      // Newest bit enters at bit 0; the first bit sent ends up at the top.
      if (strobes.shiftBit) shiftReg <= {shiftReg[WORD_W-2:0], dataBit};
      if (strobes.loadLatch) latchWord <= shiftReg;
      updateStrobe <= strobes.loadLatch;
      pathReg      <= loopEnIn;
    end
  end

  // Binary-weighted sections: code bit k drives the 2^k dB section of its stage.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    for (genvar k = 0; k < CODE_W; k++) begin : g_section
      assign sectionEn[s*CODE_W + k] = latchWord[s*CODE_W + k];
    end
  end

  assign attnPathSel  = pathReg;
  assign mixerPathSel = ~pathReg;
endmodule

// File: rtl/attn_serial_ctrl.sv
module attn_serial_ctrl
  import attn_ctrl_pkg::*;
#(
  parameter int CODE_W      = 5,
  parameter int SYNC_STAGES = 2,
  localparam int STAGES = 2,
  localparam int WORD_W = CODE_W * STAGES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLe,
  input  logic              loopEnIn,
  output logic [CODE_W-1:0] stage1Code,
  output logic [CODE_W-1:0] stage2Code,
  output logic [WORD_W-1:0] sectionEn,
  output logic              updateStrobe,
  output logic              attnPathSel,
  output logic              mixerPathSel
);
  ctrlStrobe_t       strobes;
  logic              dataBit;
  logic [WORD_W-1:0] latchWord;

  attn_ctrl_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .serClk  (serClk),
    .serData (serData),
    .serLe   (serLe),
    .strobes (strobes),
    .dataBit (dataBit)
  );

  attn_ctrl_datapath #(.CODE_W(CODE_W), .STAGES(STAGES)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .dataBit      (dataBit),
    .loopEnIn     (loopEnIn),
    .latchWord    (latchWord),
    .sectionEn    (sectionEn),
    .updateStrobe (updateStrobe),
    .attnPathSel  (attnPathSel),
    .mixerPathSel (mixerPathSel)
  );

  assign stage1Code = latchWord[CODE_W-1:0];
  assign stage2Code = latchWord[WORD_W-1:CODE_W];
endmodule

// File: rtl/attn_serial_ctrl_chk.sv
module attn_serial_ctrl_chk #(
  parameter int CODE_W = 5,
  localparam int WORD_W = CODE_W * 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              loopEnIn,
  input logic [CODE_W-1:0] stage1Code,
  input logic [CODE_W-1:0] stage2Code,
  input logic [WORD_W-1:0] sectionEn,
  input logic              updateStrobe,
  input logic              attnPathSel,
  input logic              mixerPathSel
);
  AST_CODES_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({stage2Code, stage1Code}) |-> updateStrobe); // R3

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    updateStrobe |=> !updateStrobe); // R9

  AST_SECTIONS_MATCH_CODES: assert property (@(posedge clk) disable iff (!rstN)
    sectionEn == {stage2Code, stage1Code}); // R5

  AST_PATH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({attnPathSel, mixerPathSel}) == 1); // R7

  AST_PATH_FOLLOWS_LOOPEN: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> attnPathSel == $past(loopEnIn)); // R7
endmodule

bind attn_serial_ctrl attn_serial_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .loopEnIn     (loopEnIn),
  .stage1Code   (stage1Code),
  .stage2Code   (stage2Code),
  .sectionEn    (sectionEn),
  .updateStrobe (updateStrobe),
  .attnPathSel  (attnPathSel),
  .mixerPathSel (mixerPathSel)
);

// File: tb/attn_serial_ctrl_tb.sv
module attn_serial_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serClk = 1'b0;
  logic       serData = 1'b0;
  logic       serLe = 1'b0;
  logic       loopEnIn = 1'b1;
  logic [4:0] stage1Code;
  logic [4:0] stage2Code;
  logic [9:0] sectionEn;
  logic       updateStrobe;
  logic       attnPathSel;
  logic       mixerPathSel;

  int checks = 0;
  int fails = 0;
  int strobesSeen = 0;
  int wordsLatched = 0;
  logic [9:0] expQ[$];
  logic [9:0] benchShift = '0;
  logic [9:0] lastLatched = '0;

  always #4 clk = ~clk;  // 125 MHz

  attn_serial_ctrl u_dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLe(serLe),
    .loopEnIn(loopEnIn), .stage1Code(stage1Code), .stage2Code(stage2Code),
    .sectionEn(sectionEn), .updateStrobe(updateStrobe),
    .attnPathSel(attnPathSel), .mixerPathSel(mixerPathSel)
  );

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Raise LE, shift n bits MSB first, optionally drop LE.
  task automatic sendBits(input logic [15:0] bits, input int n, input bit doLatch);
    serLe = 1'b1;
    waitClk(4);
    for (int i = n - 1; i >= 0; i--) begin
      serData = bits[i];
      waitClk(4);
      serClk = 1'b1;
      waitClk(4);
      serClk = 1'b0;
      benchShift = {benchShift[8:0], bits[i]};
      waitClk(4);
    end
    if (doLatch) dropLe();
  endtask

  task automatic dropLe();
    expQ.push_back(benchShift);
    lastLatched = benchShift;
    wordsLatched++;
    serLe = 1'b0;
    waitClk(12);
  endtask

  // Monitor: each update pulse consumes one expected word.
  always @(negedge clk) begin
    if (rstN && updateStrobe) begin
      strobesSeen++;
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9: actual unexpected update expected none");
      end else begin
        logic [9:0] e;
        e = expQ.pop_front();
        checkEq("R1 R2 R4 stage1Code", 32'(stage1Code), 32'(e[4:0]));
        checkEq("R1 R2 R4 stage2Code", 32'(stage2Code), 32'(e[9:5]));
        checkEq("R5 sectionEn", 32'(sectionEn), 32'(e));
      end
    end
  end

  initial begin
    fork
      begin
        waitClk(150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        waitClk(5);
        checkEq("R8 stage1Code", 32'(stage1Code), 0);
        checkEq("R8 stage2Code", 32'(stage2Code), 0);
        checkEq("R8 sectionEn", 32'(sectionEn), 0);
        checkEq("R8 updateStrobe", 32'(updateStrobe), 0);
        rstN = 1'b1;
        waitClk(3);

        loopEnIn = 1'b0;
        waitClk(1);
        checkEq("R7 attn low", 32'(attnPathSel), 0);
        checkEq("R7 mixer high", 32'(mixerPathSel), 1);
        loopEnIn = 1'b1;
        waitClk(1);
        checkEq("R7 attn high", 32'(attnPathSel), 1);
        checkEq("R7 mixer low", 32'(mixerPathSel), 0);

        sendBits(16'h2B3, 10, 1'b1);          // mixed word
        sendBits(16'h3FF, 10, 1'b1);          // R6 all ones
        checkEq("R6 all ones sections", 32'(sectionEn), 32'h3FF);
        sendBits(16'h000, 10, 1'b1);          // R6 all zeros
        checkEq("R6 all zeros stage1", 32'(stage1Code), 0);
        sendBits(16'h015, 10, 1'b1);          // R4 low half only
        sendBits(16'h300, 10, 1'b1);          // R5 top sections

        // R3: shift a full word with LE held high, outputs must hold.
        sendBits(16'h155, 10, 1'b0);
        checkEq("R3 stage1 held", 32'(stage1Code), 32'(lastLatched[4:0]));
        checkEq("R3 stage2 held", 32'(stage2Code), 32'(lastLatched[9:5]));
        checkEq("R3 no strobe", 32'(updateStrobe), 0);
        dropLe();

        sendBits(16'h00B, 4, 1'b1);           // R10 short word
        sendBits(16'h1A5C, 13, 1'b1);         // R10 long word
        checkEq("R10 long word stage2", 32'(stage2Code), 32'(benchShift[9:5]));

        waitClk(10);
        checkEq("R9 one strobe per latch", 32'(strobesSeen), 32'(wordsLatched));
        checkEq("R9 queue drained", 32'(expQ.size()), 0);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule